// File: doc/BRIEF.md
# Speed-Tracking Two-Gear Shift Controller

This block tracks a vehicle speed in whole-mph units and picks one of two gears from it. On every clock cycle a single direction bit either raises the stored speed by one (accelerating) or lowers it by one (braking). The speed register saturates at both ends, so it never wraps.

A comparator checks the registered speed against a fixed shift point. A small two-state control machine then settles on the LOW or HIGH gear on the following clock edge. A lamp output lights whenever the gear is HIGH. The current speed is presented directly on an output for a display elsewhere.

Reset is synchronous. It returns the speed to zero and the gear to LOW, with the lamp dark.

Top module: `gear_shift_ctrl`

## Requirements
- R1: With `rst` high at a rising clock edge, after that edge `speed` is 0, `gear_high` is 0 (LOW) and `lamp` is 0.
- R2: With `rst` low, `accel` = 1 and `speed` below 255, the next edge raises `speed` by exactly 1.
- R3: With `rst` low, `accel` = 0 and `speed` above 0, the next edge lowers `speed` by exactly 1.
- R4: With `accel` = 1 and `speed` = 255, the next edge leaves `speed` at 255.
- R5: With `accel` = 0 and `speed` = 0, the next edge leaves `speed` at 0.
- R6: With `rst` low, after each edge `gear_high` is 1 (HIGH) when the speed held just before that edge was 75 or more, and 0 (LOW) when it was below 75.
- R7: The shift point is inclusive on the HIGH side: a speed of 75 selects HIGH and a speed of 74 selects LOW, one edge later.
- R8: `lamp` equals `gear_high` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| accel | input | 1 | 1 = accelerate (speed up), 0 = brake (speed down) |
| speed | output | 8 | Registered speed in mph |
| gear_high | output | 1 | Selected gear: 0 = LOW, 1 = HIGH |
| lamp | output | 1 | Indicator, lit when gear is HIGH |

## Verification
A long run of accelerate cycles sweeps the speed through every value from 0 to the top. It crosses the shift point upward and then holds at the ceiling, which separates plain increments from saturation. A long brake run covers the same ground downward and ends pinned at zero. Rapid alternation of the direction bit around 74 and 75 tests the one-edge lag of the gear and the inclusive shift point. A reset issued while the speed is high shows that reset clears the speed, gear and lamp together.

// File: rtl/gear_pkg.sv
package gear_pkg;

    typedef enum logic {
        GEAR_LOW  = 1'b0,
        GEAR_HIGH = 1'b1
    } gear_e;

    typedef struct packed {
        logic [7:0] speed;
        gear_e      gear;
        logic       lamp;
    } gear_regs_t;

endpackage

// File: rtl/speed_step.sv
module speed_step #(
    parameter int SPEED_W = 8
) (
    input  logic [SPEED_W-1:0] cur,
    input  logic               up,
    output logic [SPEED_W-1:0] nxt
);
    localparam logic [SPEED_W-1:0] TOP = {SPEED_W{1'b1}};
    localparam logic [SPEED_W-1:0] ONE = {{(SPEED_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (up) begin
            nxt = (cur == TOP) ? cur : cur + ONE;
        end else begin
            nxt = (cur == '0) ? cur : cur - ONE;
        end
    end
endmodule

// File: rtl/speed_cmp.sv
module speed_cmp #(
    parameter int SPEED_W = 8,
    parameter int SHIFT_AT = 75
) (
    input  logic [SPEED_W-1:0] cur,
    output logic               below
);
    localparam logic [SPEED_W-1:0] LIMIT = SHIFT_AT[SPEED_W-1:0];

    assign below = (cur < LIMIT);
endmodule

// File: rtl/gear_ctrl.sv
module gear_ctrl
    import gear_pkg::*;
(
    input  gear_e cur,
    input  logic  below,
    input  logic  accel,
    output gear_e nxt,
    output logic  lamp_nxt,
    output logic  step_up
);
    always_comb begin
        unique case (cur)
            GEAR_LOW:  nxt = below ? GEAR_LOW : GEAR_HIGH;
            GEAR_HIGH: nxt = below ? GEAR_LOW : GEAR_HIGH;
            default:   nxt = GEAR_LOW;
        endcase
        lamp_nxt = (nxt == GEAR_HIGH);
        step_up  = accel;
    end
endmodule

// File: rtl/gear_shift_ctrl.sv
module gear_shift_ctrl
    import gear_pkg::*;
#(
    parameter int SPEED_W = 8,
    parameter int SHIFT_AT = 75
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accel,
    output logic [SPEED_W-1:0] speed,
    output logic               gear_high,
    output logic               lamp
);
    gear_regs_t regs_d, regs_q;

    logic [SPEED_W-1:0] spd_step_d;
    logic               below_lim;
    gear_e              gear_nxt;
    logic               lamp_nxt;
    logic               step_up;

    gear_ctrl u_ctrl (
        .cur      (regs_q.gear),
        .below    (below_lim),
        .accel    (accel),
        .nxt      (gear_nxt),
        .lamp_nxt (lamp_nxt),
        .step_up  (step_up)
    );

    speed_step #(.SPEED_W(SPEED_W)) u_step (
        .cur (regs_q.speed[SPEED_W-1:0]),
        .up  (step_up),
        .nxt (spd_step_d)
    );

    speed_cmp #(.SPEED_W(SPEED_W), .SHIFT_AT(SHIFT_AT)) u_cmp (
        .cur   (regs_q.speed[SPEED_W-1:0]),
        .below (below_lim)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.speed = '0;
            regs_d.gear  = GEAR_LOW;
            regs_d.lamp  = 1'b0;
        end else begin
            regs_d.speed = 8'(spd_step_d);
            regs_d.gear  = gear_nxt;
            regs_d.lamp  = lamp_nxt;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign speed     = regs_q.speed[SPEED_W-1:0];
    assign gear_high = (regs_q.gear == GEAR_HIGH);
    assign lamp      = regs_q.lamp;
endmodule

// File: rtl/gear_shift_chk.sv
module gear_shift_chk #(
    parameter int SPEED_W = 8,
    parameter int SHIFT_AT = 75
) (
    input logic               clk,
    input logic               rst,
    input logic               accel,
    input logic [SPEED_W-1:0] speed,
    input logic               gear_high,
    input logic               lamp
);
    localparam logic [SPEED_W-1:0] TOP = {SPEED_W{1'b1}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (speed == '0 && !gear_high && !lamp));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (accel && speed != TOP) |=> (speed == $past(speed) + 1'b1));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!accel && speed != '0) |=> (speed == $past(speed) - 1'b1));

    assert_hold_top_R4: assert property (@(posedge clk) disable iff (rst)
        (accel && speed == TOP) |=> (speed == TOP));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!accel && speed == '0) |=> (speed == '0));

    assert_gear_follow_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (gear_high == ($past(speed) >= SHIFT_AT)));

    assert_lamp_match_R8: assert property (@(posedge clk)
        lamp == gear_high);
endmodule

bind gear_shift_ctrl gear_shift_chk #(.SPEED_W(SPEED_W), .SHIFT_AT(SHIFT_AT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accel     (accel),
    .speed     (speed),
    .gear_high (gear_high),
    .lamp      (lamp)
);

// File: tb/gear_shift_ctrl_tb.sv
module gear_shift_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       accel = 1'b0;
    logic [7:0] speed;
    logic       gear_high;
    logic       lamp;

    int total = 0;
    int bad = 0;
    int exp_speed = 0;
    int exp_gear = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gear_shift_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .accel     (accel),
        .speed     (speed),
        .gear_high (gear_high),
        .lamp      (lamp)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        exp_speed = 0;
        exp_gear = 0;
        check("R1 speed", speed, 0);
        check("R1 gear", gear_high, 0);
        check("R1 lamp", lamp, 0);
        rst = 1'b0;
    endtask

    task automatic step(input bit a);
        int prev;
        string sreq;
        string greq;
        rst = 1'b0;
        accel = a;
        prev = exp_speed;
        @(negedge clk);
        exp_gear = (prev >= 75) ? 1 : 0;
        if (a) begin
            sreq = (prev == 255) ? "R4" : "R2";
            exp_speed = (prev == 255) ? 255 : prev + 1;
        end else begin
            sreq = (prev == 0) ? "R5" : "R3";
            exp_speed = (prev == 0) ? 0 : prev - 1;
        end
        greq = (prev == 74 || prev == 75) ? "R7" : "R6";
        check(sreq, speed, exp_speed);
        check(greq, gear_high, exp_gear);
        check("R8", lamp, gear_high);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < 300; i++) step(1'b1);
        for (int i = 0; i < 300; i++) step(1'b0);
        for (int i = 0; i < 74; i++) step(1'b1);
        for (int i = 0; i < 20; i++) step(i[0] ? 1'b0 : 1'b1);
        for (int i = 0; i < 12; i++) step(i[1]);
        for (int i = 0; i < 100; i++) step(1'b1);
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b0);
        for (int i = 0; i < 80; i++) step(1'b1);
        for (int i = 0; i < 10; i++) step(1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule